// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Sequencer

This block is the digital timing core of a free-running, peak-current-mode flyback controller. It receives three one-bit comparator results (transformer demagnetization, current-sense trip, skip condition) and one enable, and it produces the gate-drive enable for the primary switch. There is no fixed oscillator. A conduction interval ends when the sensed primary current reaches its setpoint, except during a blanking window just after turn-on. The next interval begins on a valley crossing of the auxiliary winding once a minimum off-time has passed. If the ringing has decayed too far to be detected, a quiet-time timeout starts it instead.

Analog comparators, setpoint scaling and the skip offset current all sit outside the block. Every interval is counted in clock cycles and set by parameters (blanking, minimum off-time, ringing-loss timeout). The demagnetization and skip inputs are asynchronous and are synchronized inside the block. The current-sense trip and the enable must already be synchronous to the clock.

Top module: `qr_cycle_seq`

## Requirements
- R1: While reset is asserted and immediately after it is released, `gate_on` is low. Reset leaves the minimum off-time already satisfied, so the first valley or timeout may start switching.
- R2: While the gate is on and at least `LEB_CYC` cycles have passed since it rose, a high `cs_trip` drives `gate_on` low on the next clock edge.
- R3: `cs_trip` is ignored during the first `LEB_CYC` on-cycles. With `cs_trip` held high, each pulse lasts exactly `LEB_CYC+1` cycles.
- R4: Once the gate has fallen, it stays low for at least `MIN_OFF_CYC+1` cycles. A valley that arrives inside this window is discarded and is not remembered.
- R5: A valley is a high-to-low transition of `dmg_in`, where high means the auxiliary voltage is above its threshold. A valley that arrives after the minimum off-time, with skip inactive and `run_en` high, raises `gate_on` on the third rising clock edge after `dmg_in` changes (two synchronizer stages plus one edge-detect stage).
- R6: After `TIMEOUT_CYC` consecutive gate-off, enabled cycles with no synchronized `dmg_in` transition, a turn-on permission is raised. The permission stays pending until the minimum off-time has elapsed and skip is inactive, and then it starts a pulse.
- R7: Every synchronized `dmg_in` transition, rising or falling, restarts the timeout count. A transition in the cycle in which the count would grant permission withdraws that permission.
- R8: While the synchronized `skip_in` is high, meaning skip is active, no pulse starts. Valleys seen during skip are discarded, and a pending timeout permission waits until skip is released.
- R9: When `run_en` is low, `gate_on` is low in that same cycle. The gate state is cleared on the next edge, the timeout count is cleared, and no pulse can start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Synchronous enable; low forces the gate off and clears pending restarts |
| dmg_in | input | 1 | Asynchronous demagnetization comparator; high = auxiliary voltage above threshold |
| skip_in | input | 1 | Asynchronous skip comparator; high = feedback below skip level |
| cs_trip | input | 1 | Synchronous current-sense comparator; high = setpoint reached |
| gate_on | output | 1 | Gate-drive enable for the primary switch |

## Verification
The two functions that can collide are timeout expiry and a demagnetization transition. A transition that reaches the edge detector in the exact cycle the quiet counter saturates must cancel the timeout grant. If that transition is a valley, it may still start the pulse on its own. Randomly toggled `dmg_in`, with the timeout set shorter than the minimum off-time, repeatedly lands transitions on the saturation cycle. A behavioural model in the bench with integer ages decides the expected gate on every cycle. A second coincidence comes from holding `cs_trip` high across the blanking boundary, and the measured pulse width judges it.

// File: rtl/qr_cycle_seq.sv
module qr_cycle_seq #(
  parameter int LEB_CYC     = 95,
  parameter int MIN_OFF_CYC = 2500,
  parameter int TIMEOUT_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic dmg_in,
  input  logic skip_in,
  input  logic cs_trip,
  output logic gate_on
);

  localparam int LW = $clog2(LEB_CYC + 1);
  localparam int OW = $clog2(MIN_OFF_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [LW-1:0] LEB_MAX = LW'(LEB_CYC);
  localparam logic [OW-1:0] OFF_MAX = OW'(MIN_OFF_CYC);
  localparam logic [TW-1:0] TMO_MAX = TW'(TIMEOUT_CYC);

  logic [1:0]    dmg_sync, skip_sync;
  logic          dmg_d, gate_q;
  logic [LW-1:0] on_cnt;
  logic [OW-1:0] off_cnt;
  logic [TW-1:0] tmo_cnt;

  logic dmg_s, skip_s, dmg_edge, dmg_fall;
  logic leb_done, moff_done, tmo_hit, start, stop, gate_nxt;

  assign dmg_s     = dmg_sync[1];
  assign skip_s    = skip_sync[1];
  assign dmg_edge  = dmg_s ^ dmg_d;
  assign dmg_fall  = dmg_d & ~dmg_s;
  assign leb_done  = (on_cnt == LEB_MAX);
  assign moff_done = (off_cnt == OFF_MAX);
  assign tmo_hit   = (tmo_cnt == TMO_MAX) & ~dmg_edge;
  assign start     = run_en & ~gate_q & moff_done & ~skip_s & (dmg_fall | tmo_hit);
  assign stop      = gate_q & (~run_en | (cs_trip & leb_done));
  assign gate_nxt  = gate_q ? ~stop : start;
  assign gate_on   = gate_q & run_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmg_sync  <= '0;
      skip_sync <= '0;
      dmg_d     <= 1'b0;
    end else begin
      dmg_sync  <= {dmg_sync[0], dmg_in};
      skip_sync <= {skip_sync[0], skip_in};
      dmg_d     <= dmg_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      on_cnt <= '0;
    else if (start)                  on_cnt <= '0;
    else if (gate_q && !leb_done)    on_cnt <= on_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      off_cnt <= OFF_MAX;
    else if (gate_q && !gate_nxt)    off_cnt <= '0;
    else if (!gate_q && !moff_done)  off_cnt <= off_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            tmo_cnt <= '0;
    else if (!run_en || gate_q || dmg_edge) tmo_cnt <= '0;
    else if (tmo_cnt != TMO_MAX)           tmo_cnt <= tmo_cnt + 1'b1;
  end

endmodule

// File: rtl/qr_cycle_seq_chk.sv
module qr_cycle_seq_chk #(
  parameter int LEB_CYC     = 95,
  parameter int MIN_OFF_CYC = 2500,
  parameter int TIMEOUT_CYC = 1250
) (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic cs_trip,
  input logic gate_q,
  input logic skip_s
);

  int ck_on, ck_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_on  <= 0;
      ck_off <= MIN_OFF_CYC;
    end else begin
      ck_on  <= !gate_q ? 0 : ((ck_on < LEB_CYC) ? ck_on + 1 : ck_on);
      ck_off <= gate_q ? 0 : ((ck_off < MIN_OFF_CYC) ? ck_off + 1 : ck_off);
    end
  end

  a_r2_trip_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && run_en && cs_trip && ck_on >= LEB_CYC) |=> !gate_q);

  a_r3_blank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && run_en && ck_on < LEB_CYC) |=> gate_q);

  a_r4_min_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_q && ck_off < MIN_OFF_CYC) |=> !gate_q);

  a_r8_skip_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_q && skip_s) |=> !gate_q);

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !gate_q);

  a_r5_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_q) |-> $past(run_en && !skip_s));

endmodule

bind qr_cycle_seq qr_cycle_seq_chk #(
  .LEB_CYC(LEB_CYC), .MIN_OFF_CYC(MIN_OFF_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .cs_trip(cs_trip),
  .gate_q(gate_q), .skip_s(skip_s)
);

// File: tb/qr_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module qr_cycle_seq_tb_top;

  localparam int LEB  = 6;
  localparam int MOFF = 20;
  localparam int TMO  = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run_en = 1'b0, dmg_in = 1'b1, skip_in = 1'b0, cs_trip = 1'b0;
  logic gate_on;

  always #2 clk = ~clk;

  qr_cycle_seq #(.LEB_CYC(LEB), .MIN_OFF_CYC(MOFF), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .dmg_in(dmg_in),
    .skip_in(skip_in), .cs_trip(cs_trip), .gate_on(gate_on)
  );

  int checks = 0, errors = 0;
  string phase = "R1";
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_gate, dm1, dm2, dm3, sk1, sk2;
  int on_age, off_age, quiet;
  bit e_v, f_v, st_v, sp_v, nx_v;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_gate = 0; on_age = 0; off_age = MOFF; quiet = 0;
      dm1 = 0; dm2 = 0; dm3 = 0; sk1 = 0; sk2 = 0;
    end else begin
      e_v  = (dm2 != dm3);
      f_v  = dm3 && !dm2;
      st_v = run_en && !m_gate && off_age >= MOFF && !sk2 && (f_v || (quiet >= TMO && !e_v));
      sp_v = m_gate && (!run_en || (cs_trip && on_age >= LEB));
      nx_v = m_gate ? !sp_v : st_v;
      if (!run_en || m_gate || e_v) quiet = 0; else quiet++;
      if (st_v) on_age = 0; else if (m_gate) on_age++;
      if (m_gate && !nx_v) off_age = 0; else if (!m_gate) off_age++;
      m_gate = nx_v;
      dm3 = dm2; dm2 = dm1; dm1 = dmg_in;
      sk2 = sk1; sk1 = skip_in;
    end
  end

  // per-cycle comparison and pulse-shape monitor
  bit prev_g = 0, seen_fall = 0;
  int hi_len = 0, lo_len = 0, rises = 0;

  always @(negedge clk) begin
    #1;
    check(gate_on == (m_gate && run_en), phase, gate_on, m_gate && run_en);
    if (gate_on && !prev_g) begin
      rises++;
      if (seen_fall) check(lo_len >= MOFF + 1, "R4", lo_len, MOFF + 1);
      hi_len = 1;
    end else if (gate_on) hi_len++;
    if (!gate_on && prev_g) begin
      seen_fall = 1;
      if (phase == "R3") check(hi_len == LEB + 1, "R3", hi_len, LEB + 1);
      lo_len = 1;
    end else if (!gate_on) lo_len++;
    prev_g = gate_on;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rand_run(input int n, input int p_dmg, input int p_cs,
                          input int p_skip, input int p_dis);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if ($urandom_range(99) < p_dmg) dmg_in = ~dmg_in;
      cs_trip = ($urandom_range(99) < p_cs);
      if ($urandom_range(99) < p_skip) skip_in = ~skip_in;
      run_en = !($urandom_range(99) < p_dis);
    end
  endtask

  initial begin
    phase = "R1";
    wait_cyc(5);
    check(gate_on == 0, "R1", gate_on, 0);
    rst_n = 1'b1; run_en = 1'b1;
    wait_cyc(1);
    check(gate_on == 0, "R1", gate_on, 0);
    wait_cyc(TMO + 4);
    check(rises == 1, "R6", rises, 1);

    phase = "R3"; cs_trip = 1'b1;
    wait_cyc(300);
    check(rises > 5, "R2", rises, 6);

    phase = "R5"; cs_trip = 1'b0;
    for (int k = 0; k < 30; k++) begin
      wait_cyc(8); dmg_in = 1'b1; cs_trip = 1'b1;
      wait_cyc(17); dmg_in = 1'b0; cs_trip = 1'b0;
    end

    phase = "R4"; rand_run(2000, 40, 30, 0, 0);
    phase = "R7"; rand_run(2000, 8, 20, 0, 0);

    phase = "R8"; skip_in = 1'b1; cs_trip = 1'b1;
    wait_cyc(4); rises = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); dmg_in = ~dmg_in;
    end
    check(rises == 0, "R8", rises, 0);
    skip_in = 1'b0;
    rand_run(2000, 20, 25, 6, 0);

    phase = "R9"; run_en = 1'b0; dmg_in = 1'b1; skip_in = 1'b0;
    wait_cyc(1); rises = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); dmg_in = ~dmg_in;
    end
    check(rises == 0, "R9", rises, 0);
    rand_run(2000, 20, 25, 4, 8);

    phase = "R6"; run_en = 1'b1; skip_in = 1'b0; dmg_in = 1'b1; cs_trip = 1'b1;
    wait_cyc(10); rises = 0;
    wait_cyc(200);
    check(rises > 3, "R6", rises, 4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule